// File: doc/BRIEF.md
# Sample-Point Delay Calibration and Phase Tuner

This block controls a programmable receive delay line. It finds a working sample point for high-speed card transfers in two stages. The first stage calibrates the size of one delay unit. With the line and its sampler enabled and the calibration phase select applied, the block tries unit settings in rising order from zero. For each setting it waits, up to a bounded time, for the line to report a measured length. It keeps the first setting whose length is usable. The highest set bit of that length gives the top usable output phase.

The second stage turns the sampler off and steps the phase select from zero up to that top phase. At each phase it asks an external test port to run a tuning transfer and report pass or fail. The block then finds the longest unbroken run of passing phases and picks its middle phase. It disables the line for one cycle, then enables it again at the chosen phase.

When the block finishes, it raises a one-cycle completion pulse and a status bit. The status bit reads as a pass or as a failure of either stage. The delay line and the card command logic sit outside this block.

Top module: `dly_tune_ctrl`

## Requirements
- R1: While reset is held and after it is released, the line enable, sampler enable, tuning request and completion outputs are all low.
- R2: During calibration the line and sampler are both enabled and the phase select is 12 (taps + 1). The unit setting starts at 0 and rises by exactly one for each new attempt.
- R3: If the length-valid flag does not appear within TIMEOUT_US × CYC_PER_US cycles of waiting, the unit is abandoned and the next one is tried. A timed-out unit is presented for one setup cycle plus the full timeout.
- R4: A reported length is accepted only if it is nonzero and below 2048 (2^11). Zero, 2048 and larger values cause the next unit to be tried. Unit 127 is still eligible.
- R5: If all 128 unit values are rejected, the block completes with status 0 and the line disabled.
- R6: The phase sweep runs from 0 up to the index of the highest set bit of the accepted length. The sampler is off and the unit is held at the accepted value. Exactly one tuning request is issued per phase, in rising phase order.
- R7: The chosen phase is the last phase of the longest passing run minus half that run's length, rounded down. Among runs of equal length, the earliest run wins.
- R8: Before the chosen phase is applied, the line enable goes low for exactly one cycle. On completion the line is enabled, the sampler is off, and the chosen phase is driven.
- R9: If no phase passes, the block completes with status 0 and the line disabled.
- R10: Completion is a single-cycle pulse. The status bit holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin calibration and tuning (taken when idle) |
| len_i | input | LEN_W (12) | Length measured by the delay line |
| len_valid_i | input | 1 | Length measurement is complete |
| tune_ack_i | input | 1 | Test port has finished the tuning transfer |
| tune_pass_i | input | 1 | Tuning transfer passed (valid with ack) |
| line_en_o | output | 1 | Delay line enable |
| samp_en_o | output | 1 | Length sampler enable |
| unit_o | output | UNIT_W (7) | Unit delay setting |
| phase_o | output | PH_W (4) | Output phase select |
| tune_req_o | output | 1 | Request one tuning transfer |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Status of the last run (1 = phase applied) |

## Verification
Calibration is tried with a mix of rejected units before one is accepted. The mix includes a zero length, lengths of exactly 2048 and above, and a unit that never reports. This separates the acceptance bound from the timeout path and confirms the exact timeout length. A sweep in which every unit is rejected shows the failure exit, and a case where only unit 127 is accepted shows the last unit is still tried.

Phase selection is tried with two separate runs of different lengths and with two runs of equal length, which shows the earliest-wins rule. A full passing sweep of eleven phases and a single-phase sweep exercise the rounding of the midpoint at both ends. A sweep where every phase fails shows the tuning failure exit.

// File: rtl/dly_tune_pkg.sv
// Shared types and helpers for the delay calibration / phase tuner.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package dly_tune_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAL_SET,
        ST_CAL_WAIT,
        ST_PH_SET,
        ST_PH_REQ,
        ST_PH_EVAL,
        ST_PH_OFF
    } tune_state_e;

    // Index of the highest set bit; 0 when the value is zero.
    function automatic logic [4:0] top_bit(input logic [31:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = 0; i < 32; i++)
            if (v[i]) r = 5'(i);
        return r;
    endfunction

endpackage

// File: rtl/dly_tmo_ctr.sv
// Wait timer for one calibration attempt.
// Counts cycles while run_i is high; clr_i restarts it. hit_o flags the last
// cycle of the window (LIMIT cycles in total). Assumes LIMIT >= 1.
module dly_tmo_ctr #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Cycle counter for the current attempt.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt_q <= '0;
        else if (run_i && !hit_o)
            cnt_q <= cnt_q + 1'b1;
    end

    assign hit_o = run_i && (cnt_q == CW'(LIMIT - 1));

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/dly_run_track.sv
// Tracks runs of passing phases during the tuning sweep.
// Each step_i records one result for phase_i. It keeps the longest run (the
// earliest on a tie) and its last phase. centre_o = last phase - length/2.
// Assumes the phases are presented in rising order after clr_i.
module dly_run_track #(
    parameter int PH_W  = 4,
    parameter int RUN_W = PH_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            step_i,
    input  logic            pass_i,
    input  logic [PH_W-1:0] phase_i,
    output logic [RUN_W-1:0] best_o,
    output logic [PH_W-1:0] centre_o
);
    logic [RUN_W-1:0] cur_q, best_q;
    logic [PH_W-1:0]  end_q;
    logic [RUN_W-1:0] cur_nx;

    assign cur_nx = pass_i ? cur_q + 1'b1 : '0;

    // Current run, best run and where the best run ended.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cur_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (step_i) begin
            cur_q <= cur_nx;
            if (cur_nx > best_q) begin
                best_q <= cur_nx;
                end_q  <= phase_i;
            end
        end
    end

    assign best_o   = best_q;
    assign centre_o = end_q - PH_W'(best_q >> 1);

    a_r7_centre_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (best_q != '0) |-> (centre_o <= end_q));
    a_r7_run_ge_best: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= best_q);

endmodule

// File: rtl/dly_tune_ctrl.sv
// Sample-point delay calibration and phase tuner, top level.
// Runs the unit calibration, then the phase sweep, then applies the centre of
// the longest passing window. Assumes the line clears its length-valid flag
// when its configuration changes, and that ack is a single-cycle pulse.
module dly_tune_ctrl
    import dly_tune_pkg::*;
#(
    parameter int UNIT_W     = 7,
    parameter int PH_W       = 4,
    parameter int LEN_W      = 12,
    parameter int TAPS       = 11,
    parameter int TIMEOUT_US = 1000,
    parameter int CYC_PER_US = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              len_valid_i,
    input  logic              tune_ack_i,
    input  logic              tune_pass_i,
    output logic              line_en_o,
    output logic              samp_en_o,
    output logic [UNIT_W-1:0] unit_o,
    output logic [PH_W-1:0]   phase_o,
    output logic              tune_req_o,
    output logic              done_o,
    output logic              ok_o
);
    localparam int TMO_CYC   = TIMEOUT_US * CYC_PER_US;
    localparam int CAL_SEL   = TAPS + 1;
    localparam int LEN_LIMIT = 2 ** TAPS;
    localparam int RUN_W     = PH_W + 1;
    localparam logic [UNIT_W-1:0] UNIT_MAX = '1;

    tune_state_e       state_q;
    logic              en_q, samp_q, done_q, ok_q;
    logic [UNIT_W-1:0] unit_q;
    logic [PH_W-1:0]   phase_q, max_ph_q;
    logic              tmo_hit, len_good, trk_step, trk_clr;
    logic [RUN_W-1:0]  best_len;
    logic [PH_W-1:0]   centre;

    assign len_good = (len_i != '0) && (32'(len_i) < LEN_LIMIT);
    assign trk_clr  = (state_q == ST_IDLE) && start_i;
    assign trk_step = (state_q == ST_PH_REQ) && tune_ack_i;

    dly_tmo_ctr #(.LIMIT(TMO_CYC)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_q == ST_CAL_SET),
        .run_i (state_q == ST_CAL_WAIT),
        .hit_o (tmo_hit)
    );

    dly_run_track #(.PH_W(PH_W), .RUN_W(RUN_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (trk_clr),
        .step_i   (trk_step),
        .pass_i   (tune_pass_i),
        .phase_i  (phase_q),
        .best_o   (best_len),
        .centre_o (centre)
    );

    // Sequencer: state plus registered line configuration and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            en_q     <= 1'b0;
            samp_q   <= 1'b0;
            unit_q   <= '0;
            phase_q  <= '0;
            max_ph_q <= '0;
            done_q   <= 1'b0;
            ok_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    en_q    <= 1'b1;
                    samp_q  <= 1'b1;
                    unit_q  <= '0;
                    phase_q <= PH_W'(CAL_SEL);
                    ok_q    <= 1'b0;
                    state_q <= ST_CAL_SET;
                end
                ST_CAL_SET: state_q <= ST_CAL_WAIT;
                ST_CAL_WAIT: begin
                    if (len_valid_i && len_good) begin
                        max_ph_q <= PH_W'(top_bit(32'(len_i)));
                        phase_q  <= '0;
                        samp_q   <= 1'b0;
                        state_q  <= ST_PH_SET;
                    end else if (len_valid_i || tmo_hit) begin
                        if (unit_q == UNIT_MAX) begin
                            en_q    <= 1'b0;
                            samp_q  <= 1'b0;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            unit_q  <= unit_q + 1'b1;
                            state_q <= ST_CAL_SET;
                        end
                    end
                end
                ST_PH_SET: state_q <= ST_PH_REQ;
                ST_PH_REQ: if (tune_ack_i) begin
                    if (phase_q == max_ph_q) begin
                        state_q <= ST_PH_EVAL;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                        state_q <= ST_PH_SET;
                    end
                end
                ST_PH_EVAL: begin
                    en_q <= 1'b0;
                    if (best_len == '0) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_PH_OFF;
                    end
                end
                ST_PH_OFF: begin
                    en_q    <= 1'b1;
                    phase_q <= centre;
                    done_q  <= 1'b1;
                    ok_q    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign line_en_o  = en_q;
    assign samp_en_o  = samp_q;
    assign unit_o     = unit_q;
    assign phase_o    = phase_q;
    assign tune_req_o = (state_q == ST_PH_REQ);
    assign done_o     = done_q;
    assign ok_o       = ok_q;

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!tune_req_o && !samp_en_o));
    a_r2_cal_select: assert property (@(posedge clk) disable iff (!rst_n)
        samp_en_o |-> (line_en_o && phase_o == PH_W'(CAL_SEL)));
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en_o && $past(samp_en_o) && unit_o != $past(unit_o))
            |-> (unit_o == $past(unit_o) + 1'b1));
    a_r6_req_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        tune_req_o |-> (line_en_o && !samp_en_o && phase_o <= max_ph_q));
    a_r8_off_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PH_OFF) |=> (line_en_o && done_o));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/sim_dly_tune_ctrl.sv
// Bench: behavioural line and test-port models plus an expected-result model
// computed from the requirements, compared on every clock of each run.
module sim_dly_tune_ctrl;
    localparam int TMO_US = 4;
    localparam int CPU    = 3;
    localparam int TMO    = TMO_US * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [11:0] len_i = '0;
    logic len_valid_i = 1'b0;
    logic tune_ack_i = 1'b0;
    logic tune_pass_i = 1'b0;
    logic line_en_o, samp_en_o, tune_req_o, done_o, ok_o;
    logic [6:0] unit_o;
    logic [3:0] phase_o;

    int errors = 0;
    int checks = 0;

    int          lat  [128];
    logic [11:0] lenv [128];
    logic [15:0] pmask;

    always #2 clk = ~clk;

    dly_tune_ctrl #(.TIMEOUT_US(TMO_US), .CYC_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .len_valid_i(len_valid_i), .tune_ack_i(tune_ack_i),
        .tune_pass_i(tune_pass_i), .line_en_o(line_en_o),
        .samp_en_o(samp_en_o), .unit_o(unit_o), .phase_o(phase_o),
        .tune_req_o(tune_req_o), .done_o(done_o), .ok_o(ok_o)
    );

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Delay line model: reports after lat cycles of a stable configuration.
    int  lcnt = 0;
    bit  lprev_on = 0;
    int  lprev_unit = -1;
    always @(negedge clk) begin
        if (line_en_o && samp_en_o && lprev_on && int'(unit_o) == lprev_unit)
            lcnt++;
        else
            lcnt = 0;
        lprev_on   = line_en_o && samp_en_o;
        lprev_unit = int'(unit_o);
        len_i       = lenv[unit_o];
        len_valid_i = line_en_o && samp_en_o && lat[unit_o] >= 0 && lcnt >= lat[unit_o];
    end

    // Test port model: answers each request after two cycles.
    int acnt = 0;
    always @(negedge clk) begin
        if (tune_ack_i) begin
            tune_ack_i = 1'b0;
            acnt = 0;
        end else if (tune_req_o) begin
            acnt++;
            if (acnt >= 2) begin
                tune_ack_i  = 1'b1;
                tune_pass_i = pmask[phase_o];
            end
        end else begin
            acnt = 0;
        end
    end

    task automatic clear_cfg();
        for (int u = 0; u < 128; u++) begin
            lat[u]  = 1;
            lenv[u] = '0;
        end
        pmask = '0;
    endtask

    // Run one full calibration and tuning pass and check it cycle by cycle.
    task automatic run_case(input string tag, input int tmo_unit);
        int acc, mp, cur, best, endp, exp_ph, nreq, off_cyc, cyc, tmo_cyc, last_unit;
        bit exp_ok, prev_req, last_samp, saw_req, exp_en;
        acc = -1; mp = 0;
        for (int u = 0; u < 128; u++)
            if (acc < 0 && lat[u] >= 0 && lat[u] <= TMO && lenv[u] != 0 && lenv[u] < 12'd2048)
                acc = u;
        if (acc >= 0)
            for (int b = 0; b < 12; b++) if (lenv[acc][b]) mp = b;
        cur = 0; best = 0; endp = 0;
        for (int p = 0; p <= mp; p++) begin
            if (pmask[p]) begin
                cur++;
                if (cur > best) begin best = cur; endp = p; end
            end else cur = 0;
        end
        exp_ok = (acc >= 0) && (best > 0);
        exp_ph = endp - best / 2;
        exp_en = exp_ok;
        nreq = 0; off_cyc = 0; cyc = 0; tmo_cyc = 0; last_unit = -1;
        prev_req = 0; last_samp = 0; saw_req = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        forever begin
            cyc++;
            if (cyc > 20000) begin
                chk(0, {tag, " watchdog"}, cyc, 0);
                break;
            end
            if (samp_en_o) begin
                chk(phase_o == 4'd12 && line_en_o, "R2 cal select", phase_o, 12);
                if (last_samp && int'(unit_o) != last_unit)
                    chk(int'(unit_o) == last_unit + 1, "R2 unit step", unit_o, last_unit + 1);
                if (!last_samp && last_unit < 0)
                    chk(unit_o == 0, "R2 first unit", unit_o, 0);
                if (int'(unit_o) == tmo_unit) tmo_cyc++;
            end
            if (tune_req_o && !prev_req) begin
                chk(int'(phase_o) == nreq, "R6 phase order", phase_o, nreq);
                chk(int'(unit_o) == acc && !samp_en_o, "R6 unit held", unit_o, acc);
                nreq++;
                saw_req = 1;
            end
            if (saw_req && !line_en_o && !done_o) off_cyc++;
            prev_req  = tune_req_o;
            last_samp = samp_en_o;
            last_unit = int'(unit_o);
            if (done_o) begin
                chk(ok_o == exp_ok, {tag, " R5 R9 status"}, ok_o, exp_ok);
                chk(line_en_o == exp_en && !samp_en_o, {tag, " R5 R9 line"}, line_en_o, exp_en);
                if (acc >= 0)
                    chk(nreq == mp + 1, {tag, " R6 request count"}, nreq, mp + 1);
                if (exp_ok) begin
                    chk(int'(phase_o) == exp_ph, {tag, " R7 chosen phase"}, phase_o, exp_ph);
                    chk(off_cyc == 1, {tag, " R8 off cycle"}, off_cyc, 1);
                end
                if (tmo_unit >= 0)
                    chk(tmo_cyc == TMO + 1, {tag, " R3 timeout length"}, tmo_cyc, TMO + 1);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        chk(!done_o, {tag, " R10 pulse"}, done_o, 0);
        chk(ok_o == exp_ok, {tag, " R10 status held"}, ok_o, exp_ok);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        chk(!line_en_o && !samp_en_o && !tune_req_o && !done_o, "R1 in reset", line_en_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!line_en_o && !samp_en_o && !tune_req_o && !done_o, "R1 after reset", done_o, 0);

        // R3 R4 R7: rejects (0, >=2048, ==2048, timeout), then two runs of 3 and 5.
        clear_cfg();
        lenv[1] = 12'hC00; lenv[2] = 12'h800; lat[3] = -1; lenv[4] = 12'h2A0;
        pmask = 16'h03EE;
        run_case("mixed", 3);

        // R7: equal runs, earliest kept.
        clear_cfg();
        lenv[0] = 12'h0FF; pmask = 16'h00E7;
        run_case("tie", -1);

        // R9: no phase passes.
        clear_cfg();
        lenv[0] = 12'h010; pmask = 16'h0000;
        run_case("nopass", -1);

        // R7 boundary: full sweep of 11 phases.
        clear_cfg();
        lenv[0] = 12'h7FF; pmask = 16'hFFFF;
        run_case("full", -1);

        // R6 boundary: single phase.
        clear_cfg();
        lenv[0] = 12'h001; pmask = 16'h0001;
        run_case("single", -1);

        // R5: every unit rejected, alternating timeouts and zero lengths.
        clear_cfg();
        for (int u = 0; u < 128; u += 2) lat[u] = -1;
        run_case("allreject", 0);

        // R4: only the last unit accepted.
        clear_cfg();
        lenv[127] = 12'h004; pmask = 16'h0004;
        run_case("lastunit", -1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Global watchdog.
    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule